// File: doc/BRIEF.md
# Gated Hysteresis Peak Finder

This block watches a stream of unsigned samples, at most one per clock, and reports every local peak it finds inside a gate window. While the gate input is low, samples are not looked at. When the gate opens, the first valid sample starts a new sample index at zero and a new running minimum. The finder stays idle until a sample climbs at least a programmable rise delta above that minimum. It then follows the highest sample and its index. The first sample that falls below that maximum confirms the peak.

Each confirmed peak carries four values: its index, its amplitude, the sample just before it and the sample just after it (the one that confirmed it). A later stage can fit a parabola through these three samples. After a peak the search starts again, with the minimum set to the confirming sample, so one window can yield many closely spaced peaks. If the gate drops while a peak is still being followed, that peak is discarded.

The input stream has no back-pressure: a sample is taken in any cycle where `smp_valid` is high. The peak output is valid/ready. A presented peak stays unchanged until `pk_ready` is high while `pk_valid` is high. A peak found while the output still holds an unaccepted one is dropped, and this sets a sticky overflow flag. A peak found in the same cycle that the held one is accepted replaces it with no loss.

Top module: `hyst_peak_finder`

## Requirements
- R1: After reset `pk_valid` and `pk_overflow` are 0.
- R2: A cycle with `smp_valid` low changes neither the index, the minimum nor the search state. Peaks found with such cycles interleaved are identical to those found without them.
- R3: The first valid sample after the gate opens gets index 0 and becomes the minimum, and it never arms the search. Each later gated valid sample gets the next index (16-bit, wrapping).
- R4: While idle, a sample S arms the search when S >= MIN and S - MIN >= `rise_delta`, with unsigned 8-bit arithmetic. Otherwise MIN becomes min(MIN, S).
- R5: While searching, a sample above the held maximum replaces it, together with its index and the sample before it. A sample equal to the maximum keeps the earlier index.
- R6: While searching, a sample below the maximum emits a peak one clock later: `pk_index` and `pk_amp` are the maximum's index and value, `pk_before` is the gated sample before it and `pk_after` is the confirming sample. The finder then goes idle with MIN set to the confirming sample.
- R7: `gate_en` low in any cycle returns the finder to idle and discards a pending maximum without reporting it. The next gated sample restarts the index at 0.
- R8: While `pk_valid` is high and `pk_ready` is low, `pk_valid` stays high and all peak fields hold.
- R9: A peak confirmed while `pk_valid` is high and `pk_ready` is low is dropped, and `pk_overflow` is set and stays set until reset. A peak confirmed in a cycle where the held peak is accepted is loaded, and `pk_overflow` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_en | input | 1 | Search window; samples are looked at only while high |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | 8 | Unsigned sample value |
| rise_delta | input | 8 | Rise above the minimum that arms the search |
| pk_valid | output | 1 | A peak is presented |
| pk_ready | input | 1 | Consumer accepts the presented peak |
| pk_index | output | 16 | Sample index of the peak within the window |
| pk_amp | output | 8 | Peak amplitude |
| pk_before | output | 8 | Sample preceding the peak |
| pk_after | output | 8 | Sample following the peak (the confirming one) |
| pk_overflow | output | 1 | Sticky: a peak was dropped |

## Verification
Two functions can fall in the same cycle: a new peak being confirmed, and the consumer accepting the held peak. The bench sets this up on purpose. It holds `pk_ready` low until the sample that confirms a second peak arrives, and raises it only in that cycle. It then expects the second peak to be presented with no overflow. The same pattern with `pk_ready` still low must instead keep the first peak and set overflow. The long sweeps toggle ready, valid and gate from a pseudo-random sequence, so these cases, and gate closes that cut off a search, also occur unplanned. Each cycle is compared with an arithmetic model kept in the bench.

// File: rtl/hpk_pkg.sv
package hpk_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEEK = 1'b1
  } hunt_e;
endpackage

// File: rtl/hpk_gate_ctrl.sv
module hpk_gate_ctrl #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_en,
  input  logic          smp_valid,
  output logic          take,
  output logic          first,
  output logic [IW-1:0] idx
);
  logic          open_q;
  logic [IW-1:0] cnt_q;

  assign take  = gate_en && smp_valid;
  assign first = take && !open_q;
  assign idx   = first ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (!gate_en)  open_q <= 1'b0;
      else if (take) open_q <= 1'b1;
      if (take)      cnt_q  <= idx + 1'b1;
    end
  end

  // R3: the index that follows the first gated sample is 1
  p_first_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    first |=> (cnt_q == IW'(1)));
endmodule

// File: rtl/hpk_track_fsm.sv
module hpk_track_fsm
  import hpk_pkg::*;
#(
  parameter int SW = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_en,
  input  logic          take,
  input  logic          first,
  input  logic [IW-1:0] idx,
  input  logic [SW-1:0] smp,
  input  logic [SW-1:0] delta,
  output logic          emit,
  output logic [IW-1:0] e_idx,
  output logic [SW-1:0] e_amp,
  output logic [SW-1:0] e_prev,
  output logic [SW-1:0] e_next
);
  hunt_e         st_q;
  logic [SW-1:0] min_q, max_q, mprev_q, last_q;
  logic [IW-1:0] midx_q;
  logic          arm;

  assign arm    = (smp >= min_q) && ((smp - min_q) >= delta);
  assign emit   = take && !first && (st_q == ST_SEEK) && (smp < max_q);
  assign e_idx  = midx_q;
  assign e_amp  = max_q;
  assign e_prev = mprev_q;
  assign e_next = smp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      min_q   <= '0;
      max_q   <= '0;
      mprev_q <= '0;
      last_q  <= '0;
      midx_q  <= '0;
    end else if (!gate_en) begin
      st_q <= ST_IDLE;
    end else if (take) begin
      last_q <= smp;
      if (first) begin
        st_q  <= ST_IDLE;
        min_q <= smp;
      end else if (st_q == ST_IDLE) begin
        if (arm) begin
          st_q    <= ST_SEEK;
          max_q   <= smp;
          midx_q  <= idx;
          mprev_q <= last_q;
        end else if (smp < min_q) begin
          min_q <= smp;
        end
      end else if (smp < max_q) begin
        st_q  <= ST_IDLE;
        min_q <= smp;
      end else if (smp > max_q) begin
        max_q   <= smp;
        midx_q  <= idx;
        mprev_q <= last_q;
      end
    end
  end

  // R7: a closed gate leaves the finder idle
  p_gate_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (st_q == ST_IDLE));
  // R5: while the search continues, the held maximum never decreases
  p_max_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEEK && gate_en && !emit) |=> (max_q >= $past(max_q)));
endmodule

// File: rtl/hpk_peak_slot.sv
module hpk_peak_slot #(
  parameter int SW = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emit,
  input  logic [IW-1:0] e_idx,
  input  logic [SW-1:0] e_amp,
  input  logic [SW-1:0] e_prev,
  input  logic [SW-1:0] e_next,
  input  logic          pk_ready,
  output logic          pk_valid,
  output logic [IW-1:0] pk_index,
  output logic [SW-1:0] pk_amp,
  output logic [SW-1:0] pk_before,
  output logic [SW-1:0] pk_after,
  output logic          pk_overflow
);
  logic stalled;
  assign stalled = pk_valid && !pk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk_valid    <= 1'b0;
      pk_overflow <= 1'b0;
      pk_index    <= '0;
      pk_amp      <= '0;
      pk_before   <= '0;
      pk_after    <= '0;
    end else begin
      if (emit && !stalled) begin
        pk_valid  <= 1'b1;
        pk_index  <= e_idx;
        pk_amp    <= e_amp;
        pk_before <= e_prev;
        pk_after  <= e_next;
      end else if (pk_valid && pk_ready) begin
        pk_valid <= 1'b0;
      end
      if (emit && stalled) pk_overflow <= 1'b1;
    end
  end

  // R8: a stalled peak holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_valid && !pk_ready) |=> (pk_valid && $stable(pk_index) && $stable(pk_amp)
                                 && $stable(pk_before) && $stable(pk_after)));
  // R9: overflow is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pk_overflow |=> pk_overflow);
  // R9: overflow only rises out of a stall
  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pk_overflow) |-> $past(pk_valid && !pk_ready));
  // R6: the confirming sample lies below the peak
  p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid |-> (pk_amp > pk_after));
endmodule

// File: rtl/hyst_peak_finder.sv
module hyst_peak_finder #(
  parameter int SW = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_en,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  input  logic [SW-1:0] rise_delta,
  output logic          pk_valid,
  input  logic          pk_ready,
  output logic [IW-1:0] pk_index,
  output logic [SW-1:0] pk_amp,
  output logic [SW-1:0] pk_before,
  output logic [SW-1:0] pk_after,
  output logic          pk_overflow
);
  logic          take, first, emit;
  logic [IW-1:0] idx, e_idx;
  logic [SW-1:0] e_amp, e_prev, e_next;

  hpk_gate_ctrl #(.IW(IW)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .smp_valid(smp_valid),
    .take(take), .first(first), .idx(idx)
  );

  hpk_track_fsm #(.SW(SW), .IW(IW)) u_track (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .take(take), .first(first),
    .idx(idx), .smp(smp_data), .delta(rise_delta), .emit(emit),
    .e_idx(e_idx), .e_amp(e_amp), .e_prev(e_prev), .e_next(e_next)
  );

  hpk_peak_slot #(.SW(SW), .IW(IW)) u_slot (
    .clk(clk), .rst_n(rst_n), .emit(emit), .e_idx(e_idx), .e_amp(e_amp),
    .e_prev(e_prev), .e_next(e_next), .pk_ready(pk_ready), .pk_valid(pk_valid),
    .pk_index(pk_index), .pk_amp(pk_amp), .pk_before(pk_before),
    .pk_after(pk_after), .pk_overflow(pk_overflow)
  );
endmodule

// File: tb/hyst_peak_finder_bench.sv
module hyst_peak_finder_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        gate_en, smp_valid, pk_ready;
  logic [7:0]  smp_data, rise_delta;
  logic        pk_valid, pk_overflow;
  logic [15:0] pk_index;
  logic [7:0]  pk_amp, pk_before, pk_after;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  bit          m_open, m_seek;
  int          m_cnt, m_min, m_max, m_midx, m_mprev, m_last;
  bit          e_valid, e_ovf;
  int          e_idx, e_amp, e_prev, e_next;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  hyst_peak_finder u_hyst_peak_finder (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .smp_valid(smp_valid),
    .smp_data(smp_data), .rise_delta(rise_delta), .pk_valid(pk_valid),
    .pk_ready(pk_ready), .pk_index(pk_index), .pk_amp(pk_amp),
    .pk_before(pk_before), .pk_after(pk_after), .pk_overflow(pk_overflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    chk("R8 pk_valid", int'(pk_valid), int'(e_valid));
    chk("R9 pk_overflow", int'(pk_overflow), int'(e_ovf));
    if (e_valid) begin
      chk("R6 pk_index", int'(pk_index), e_idx);
      chk("R6 pk_amp", int'(pk_amp), e_amp);
      chk("R6 pk_before", int'(pk_before), e_prev);
      chk("R6 pk_after", int'(pk_after), e_next);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; gate_en = 1'b0; smp_valid = 1'b0; smp_data = '0; pk_ready = 1'b0;
    m_open = 0; m_seek = 0; m_cnt = 0; m_min = 0; m_max = 0; m_midx = 0;
    m_mprev = 0; m_last = 0; e_valid = 0; e_ovf = 0;
    e_idx = 0; e_amp = 0; e_prev = 0; e_next = 0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
    chk("R1 pk_valid after reset", int'(pk_valid), 0);
    chk("R1 pk_overflow after reset", int'(pk_overflow), 0);
  endtask

  // one clock: drive, advance the model, compare after the edge
  task automatic step(input bit g, input bit v, input int d, input bit r);
    bit take, first, emit, stall;
    int cidx;
    @(negedge clk);
    gate_en = g; smp_valid = v; smp_data = 8'(d); pk_ready = r;
    take  = g && v;
    first = take && !m_open;
    cidx  = first ? 0 : m_cnt;
    emit  = take && !first && m_seek && (d < m_max);
    stall = e_valid && !r;
    if (emit && !stall) begin
      e_valid = 1; e_idx = m_midx; e_amp = m_max; e_prev = m_mprev; e_next = d;
    end else if (e_valid && r) begin
      e_valid = 0;
    end
    if (emit && stall) e_ovf = 1;
    if (!g) begin
      m_open = 0; m_seek = 0;
    end else if (take) begin
      m_open = 1;
      m_cnt  = (cidx + 1) % 65536;
      if (first) begin
        m_seek = 0; m_min = d;
      end else if (!m_seek) begin
        if (d - m_min >= int'(rise_delta)) begin
          m_seek = 1; m_max = d; m_midx = cidx; m_mprev = m_last;
        end else if (d < m_min) m_min = d;
      end else if (d < m_max) begin
        m_seek = 0; m_min = d;
      end else if (d > m_max) begin
        m_max = d; m_midx = cidx; m_mprev = m_last;
      end
      m_last = d;
    end
    @(posedge clk); #1;
    compare_model();
  endtask

  task automatic expect_peak(input string tag, input int i, input int a, input int b, input int n);
    chk({tag, " valid"}, int'(pk_valid), 1);
    chk({tag, " index"}, int'(pk_index), i);
    chk({tag, " amp"}, int'(pk_amp), a);
    chk({tag, " before"}, int'(pk_before), b);
    chk({tag, " after"}, int'(pk_after), n);
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " no peak"}, int'(pk_valid), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    rise_delta = 8'd5;
    do_reset();

    // R3/R6: basic peak, first sample is the minimum
    step(1,1,10,0); step(1,1,20,0); step(1,1,30,0); step(1,1,25,0);
    expect_peak("R6 basic", 2, 30, 20, 25);
    // R9 coincidence: accept A while B is confirmed
    step(1,1,40,0); step(1,1,35,1);
    expect_peak("R9 same-cycle load", 4, 40, 25, 35);
    chk("R9 no overflow on coincident accept", int'(pk_overflow), 0);
    // R9: stalled, C confirmed and dropped
    step(1,1,50,0); step(1,1,45,0);
    expect_peak("R8 held under stall", 4, 40, 25, 35);
    chk("R9 overflow set", int'(pk_overflow), 1);
    step(1,0,0,1);
    expect_none("R8 accepted");
    step(1,0,0,0);
    chk("R9 overflow sticky", int'(pk_overflow), 1);

    // R2: invalid cycles interleaved change nothing
    do_reset();
    step(1,1,10,1); step(1,0,200,1); step(1,1,20,1); step(1,0,0,1);
    step(1,1,30,1); step(1,0,255,1); step(1,1,25,1);
    expect_peak("R2 interleaved invalid", 2, 30, 20, 25);

    // R5: equal sample keeps earlier index
    do_reset();
    step(1,1,10,1); step(1,1,20,1); step(1,1,20,1); step(1,1,15,1);
    expect_peak("R5 equal keeps first", 1, 20, 10, 15);

    // R4: threshold and minimum tracking
    do_reset();
    step(1,1,10,1); step(1,1,14,1); step(1,1,13,1); step(1,1,8,1);
    expect_none("R4 below delta");
    step(1,1,12,1); step(1,1,13,1); step(1,1,11,1);
    expect_peak("R4 armed from lowered minimum", 5, 13, 12, 11);

    // R7: gate close discards, index restarts (R3)
    do_reset();
    step(1,1,10,1); step(1,1,40,1); step(1,1,50,1); step(0,1,5,1);
    expect_none("R7 discarded on close");
    step(1,1,10,1); step(1,1,9,1);
    expect_none("R7 no stale peak");
    step(1,1,60,1); step(1,1,55,1);
    expect_peak("R3 index restarts", 2, 60, 9, 55);

    // near-exhaustive sweeps against the model
    foreach (lfsr[i]) begin end
    for (int dsel = 0; dsel < 6; dsel++) begin
      for (int rmode = 0; rmode < 3; rmode++) begin
        int dv;
        case (dsel)
          0: dv = 0; 1: dv = 1; 2: dv = 3; 3: dv = 7; 4: dv = 16; default: dv = 255;
        endcase
        do_reset();
        rise_delta = 8'(dv);
        for (int c = 0; c < 400; c++) begin
          bit g, v, r;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          g = (c % 41) < 34;
          v = lfsr[3] | lfsr[7];
          r = (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[9] : (lfsr[9] & lfsr[11]);
          step(g, v, (dsel == 5) ? int'(lfsr[15:8]) : int'(lfsr[5:0]), r);
        end
      end
    end
    // wide delta with a full-range rise: 0 then 255 arms at delta 255 (R4)
    do_reset();
    rise_delta = 8'd255;
    step(1,1,0,1); step(1,1,255,1); step(1,1,254,1);
    expect_peak("R4 full-range delta", 1, 255, 0, 254);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule